// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of a small private write-back cache on a shared snooping bus. Each line is in one of four states: Modified, Exclusive, Shared or Invalid. On the processor side it takes read and write requests that carry a line index. It answers with a ready strobe and a hit flag. When a request needs the bus, it stalls the processor until that bus transaction completes.

As a bus master it issues three kinds of transaction:
- a line read for a read miss;
- a read-for-ownership for a write miss;
- an invalidate for a write to a Shared line.

It samples a shared-response line when the transaction completes. The value of that line decides whether a filled line becomes Exclusive or Shared.

As a snooper it watches the transactions of other caches. For each one it produces three responses:
- a shared response;
- a supply-data flag, raised when this cache owns the line;
- a write-back flag, raised when the line it supplies is dirty.

It then updates the local state of the snooped line. Data storage, tags, replacement and memory timing are outside the block. They are reduced to the ready/done handshakes described below.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus transaction is pending and `cpu_rdy_o` is low. The first read of any line is therefore a miss.
- R2: A read to a line in Modified, Exclusive or Shared completes in the same cycle with `cpu_rdy_o`=1 and `cpu_hit_o`=1. It issues no bus request and leaves the state unchanged.
- R3: A read to an Invalid line raises `bus_req_o` on the next cycle with `bus_op_o`=1 (line read) and `bus_idx_o` equal to the requested index.
- R4: When a line read completes (`bus_done_i`=1), the line is installed as Shared if `bus_shared_i`=1 and as Exclusive if `bus_shared_i`=0. `cpu_rdy_o`=1 and `cpu_hit_o`=0 in that cycle.
- R5: A write to an Exclusive line completes in the same cycle as a hit and moves the line to Modified without any bus request. A write to a Modified line is also a silent hit.
- R6: A write to a Shared line issues `bus_op_o`=3 (invalidate). On completion the line becomes Modified, with `cpu_rdy_o`=1 and `cpu_hit_o`=1.
- R7: A write to an Invalid line issues `bus_op_o`=2 (read-for-ownership). On completion the line becomes Modified, with `cpu_hit_o`=0.
- R8: A snooped line read (`snp_op_i`=1) to a Modified or Exclusive line raises `snp_supply_o` in the same cycle and moves the line to Shared. For a Modified line it also raises `snp_flush_o`. A snooped line read to any valid line raises `snp_shared_o`.
- R9: A snooped read-for-ownership (`snp_op_i`=2) or invalidate (`snp_op_i`=3) moves a held line to Invalid. A read-for-ownership that finds the line Modified also raises `snp_supply_o` and `snp_flush_o`.
- R10: Only one bus transaction is outstanding at a time. While it is pending, `bus_op_o` and `bus_idx_o` are stable and `cpu_rdy_o` stays low.
- R11: A snoop on an Invalid line, or with `snp_op_i`=0, raises none of the snoop responses and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor request, held until `cpu_rdy_o` |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_idx_i | input | IDX_W | Line index of the request |
| cpu_rdy_o | output | 1 | Request completes this cycle |
| cpu_hit_o | output | 1 | Completed request was a hit |
| bus_req_o | output | 1 | Bus transaction pending |
| bus_op_o | output | 2 | 0 none, 1 line read, 2 read-for-ownership, 3 invalidate |
| bus_idx_o | output | IDX_W | Line index of the pending transaction |
| bus_done_i | input | 1 | Pending transaction completes this cycle |
| bus_shared_i | input | 1 | Another cache responded; sampled with `bus_done_i` |
| snp_valid_i | input | 1 | A remote transaction is on the bus |
| snp_op_i | input | 2 | Remote transaction kind, same encoding as `bus_op_o` |
| snp_idx_i | input | IDX_W | Line index of the remote transaction |
| snp_supply_o | output | 1 | This cache provides the line data |
| snp_flush_o | output | 1 | Supplied line is dirty; memory takes the data |
| snp_shared_o | output | 1 | This cache holds a valid copy of the read line |

## Verification
The assertions rely on three properties of the inputs:
- `bus_done_i` is raised only while `bus_req_o` is high.
- The processor holds its request and index stable until it sees `cpu_rdy_o`.
- A snoop never targets the index of the local request in flight, since the bus serialises transactions to one line.

The stimulus keeps to these rules. It raises done only after a chosen latency on a pending transaction. It also draws every snoop index from the lines other than the one the processor is using. Within these limits, directed sequences take single lines through every state transition. A long run of random accesses with background snoops then exercises mixed orderings.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    MS_I = 2'd0,
    MS_S = 2'd1,
    MS_E = 2'd2,
    MS_M = 2'd3
  } mesi_e;

  typedef enum logic [1:0] {
    BOP_NONE = 2'd0,
    BOP_RD   = 2'd1,
    BOP_RDX  = 2'd2,
    BOP_INV  = 2'd3
  } bus_op_e;
endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        loc_we_i,
  input  logic [IDX_W-1:0]            loc_idx_i,
  input  mesi_e                       loc_st_i,
  input  logic                        snp_we_i,
  input  logic [IDX_W-1:0]            snp_idx_i,
  input  mesi_e                       snp_st_i,
  output mesi_e [NUM_LINES-1:0]       lines_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    mesi_e st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q <= MS_I;
      end else if (snp_we_i && snp_idx_i == IDX_W'(g)) begin
        st_q <= snp_st_i;  // snoop wins a same-line collision
      end else if (loc_we_i && loc_idx_i == IDX_W'(g)) begin
        st_q <= loc_st_i;
      end
    end
    assign lines_o[g] = st_q;
  end
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
(
  input  logic    snp_valid_i,
  input  bus_op_e snp_op_i,
  input  mesi_e   cur_st_i,
  output logic    we_o,
  output mesi_e   next_o,
  output logic    supply_o,
  output logic    flush_o,
  output logic    shared_o
);
  always_comb begin
    we_o     = 1'b0;
    next_o   = cur_st_i;
    supply_o = 1'b0;
    flush_o  = 1'b0;
    shared_o = 1'b0;
    if (snp_valid_i && cur_st_i != MS_I) begin
      unique case (snp_op_i)
        BOP_RD: begin
          shared_o = 1'b1;
          if (cur_st_i == MS_E || cur_st_i == MS_M) begin
            supply_o = 1'b1;
            flush_o  = (cur_st_i == MS_M);
            we_o     = 1'b1;
            next_o   = MS_S;
          end
        end
        BOP_RDX: begin
          supply_o = (cur_st_i == MS_M);
          flush_o  = (cur_st_i == MS_M);
          we_o     = 1'b1;
          next_o   = MS_I;
        end
        BOP_INV: begin
          we_o   = 1'b1;
          next_o = MS_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_master_fsm.sv
module mesi_master_fsm
  import mesi_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_i,
  input  logic             cpu_we_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  input  mesi_e            cur_st_i,
  input  logic             bus_done_i,
  input  logic             bus_shared_i,
  output logic             cpu_rdy_o,
  output logic             cpu_hit_o,
  output logic             bus_req_o,
  output bus_op_e          bus_op_o,
  output logic [IDX_W-1:0] bus_idx_o,
  output logic             loc_we_o,
  output logic [IDX_W-1:0] loc_idx_o,
  output mesi_e            loc_st_o
);
  logic             pend_q, pend_d;
  bus_op_e          op_q, op_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    pend_d    = pend_q;
    op_d      = op_q;
    idx_d     = idx_q;
    cpu_rdy_o = 1'b0;
    cpu_hit_o = 1'b0;
    loc_we_o  = 1'b0;
    loc_idx_o = cpu_idx_i;
    loc_st_o  = cur_st_i;
    if (pend_q) begin
      loc_idx_o = idx_q;
      if (bus_done_i) begin
        pend_d    = 1'b0;
        cpu_rdy_o = 1'b1;
        cpu_hit_o = (op_q == BOP_INV);
        loc_we_o  = 1'b1;
        if (op_q == BOP_RD) loc_st_o = bus_shared_i ? MS_S : MS_E;
        else                loc_st_o = MS_M;
      end
    end else if (cpu_req_i) begin
      if (!cpu_we_i && cur_st_i != MS_I) begin
        cpu_rdy_o = 1'b1;
        cpu_hit_o = 1'b1;
      end else if (cpu_we_i && (cur_st_i == MS_M || cur_st_i == MS_E)) begin
        cpu_rdy_o = 1'b1;
        cpu_hit_o = 1'b1;
        loc_we_o  = (cur_st_i == MS_E);
        loc_st_o  = MS_M;
      end else begin
        pend_d = 1'b1;
        idx_d  = cpu_idx_i;
        if (!cpu_we_i)              op_d = BOP_RD;
        else if (cur_st_i == MS_S)  op_d = BOP_INV;
        else                        op_d = BOP_RDX;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      op_q   <= BOP_NONE;
      idx_q  <= '0;
    end else begin
      pend_q <= pend_d;
      op_q   <= op_d;
      idx_q  <= idx_d;
    end
  end

  assign bus_req_o = pend_q;
  assign bus_op_o  = pend_q ? op_q : BOP_NONE;
  assign bus_idx_o = idx_q;

  AST_STALL_NO_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_done_i |-> !cpu_rdy_o); // R10
  AST_HOLD_TXN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_done_i |=> bus_req_o && $stable(bus_op_o) && $stable(bus_idx_o)); // R10
  AST_RD_HIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_o && cpu_req_i && !cpu_we_i && cur_st_i != MS_I
      |=> !bus_req_o); // R2
  AST_RD_MISS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_o && cpu_req_i && !cpu_we_i && cur_st_i == MS_I
      |=> bus_req_o && bus_op_o == BOP_RD); // R3
  AST_EXCL_WR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_o && cpu_req_i && cpu_we_i && cur_st_i == MS_E |=> !bus_req_o); // R5
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_i,
  input  logic             cpu_we_i,
  input  logic [IDX_W-1:0] cpu_idx_i,
  output logic             cpu_rdy_o,
  output logic             cpu_hit_o,
  output logic             bus_req_o,
  output logic [1:0]       bus_op_o,
  output logic [IDX_W-1:0] bus_idx_o,
  input  logic             bus_done_i,
  input  logic             bus_shared_i,
  input  logic             snp_valid_i,
  input  logic [1:0]       snp_op_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  output logic             snp_supply_o,
  output logic             snp_flush_o,
  output logic             snp_shared_o
);
  mesi_e [NUM_LINES-1:0] lines;
  logic                  loc_we, snp_we;
  logic [IDX_W-1:0]      loc_idx;
  mesi_e                 loc_st, snp_st;
  bus_op_e               fsm_op;

  mesi_master_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_req_i    (cpu_req_i),
    .cpu_we_i     (cpu_we_i),
    .cpu_idx_i    (cpu_idx_i),
    .cur_st_i     (lines[cpu_idx_i]),
    .bus_done_i   (bus_done_i),
    .bus_shared_i (bus_shared_i),
    .cpu_rdy_o    (cpu_rdy_o),
    .cpu_hit_o    (cpu_hit_o),
    .bus_req_o    (bus_req_o),
    .bus_op_o     (fsm_op),
    .bus_idx_o    (bus_idx_o),
    .loc_we_o     (loc_we),
    .loc_idx_o    (loc_idx),
    .loc_st_o     (loc_st)
  );
  assign bus_op_o = fsm_op;

  mesi_snoop_unit u_snoop (
    .snp_valid_i (snp_valid_i),
    .snp_op_i    (bus_op_e'(snp_op_i)),
    .cur_st_i    (lines[snp_idx_i]),
    .we_o        (snp_we),
    .next_o      (snp_st),
    .supply_o    (snp_supply_o),
    .flush_o     (snp_flush_o),
    .shared_o    (snp_shared_o)
  );

  mesi_line_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .loc_we_i  (loc_we),
    .loc_idx_i (loc_idx),
    .loc_st_i  (loc_st),
    .snp_we_i  (snp_we),
    .snp_idx_i (snp_idx_i),
    .snp_st_i  (snp_st),
    .lines_o   (lines)
  );

  AST_FILL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_done_i && bus_op_o == 2'd1 && !bus_shared_i
      |=> lines[$past(bus_idx_o)] == MS_E); // R4
  AST_FILL_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_done_i && bus_op_o == 2'd1 && bus_shared_i
      |=> lines[$past(bus_idx_o)] == MS_S); // R4
  AST_UPGRADE_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_done_i && bus_op_o == 2'd3 |=> lines[$past(bus_idx_o)] == MS_M); // R6
  AST_RFO_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_done_i && bus_op_o == 2'd2 |=> lines[$past(bus_idx_o)] == MS_M); // R7
  AST_SNP_DEMOTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_supply_o && snp_op_i == 2'd1 |=> lines[$past(snp_idx_i)] == MS_S); // R8
  AST_SNP_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_op_i[1] |=> lines[$past(snp_idx_i)] == MS_I); // R9
  AST_SNP_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |-> !snp_supply_o && !snp_flush_o && !snp_shared_o); // R11
endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;
  localparam int NL = 8;
  localparam int IW = $clog2(NL);
  // model states: 0 I, 1 S, 2 E, 3 M
  localparam int I = 0, S = 1, E = 2, M = 3;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [IW-1:0] cpu_idx = '0;
  logic cpu_rdy, cpu_hit, bus_req;
  logic [1:0] bus_op;
  logic [IW-1:0] bus_idx;
  logic bus_done = 0, bus_shared = 0;
  logic snp_valid = 0;
  logic [1:0] snp_op = '0;
  logic [IW-1:0] snp_idx = '0;
  logic snp_supply, snp_flush, snp_shared;

  int checks = 0, errors = 0;
  int m_st [NL];
  bit m_pend = 0;
  int m_op = 0, m_idx = 0;
  bit last_rdy;

  always #10 clk = ~clk;

  mesi_snoop_ctrl #(.NUM_LINES(NL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_idx_i(cpu_idx),
    .cpu_rdy_o(cpu_rdy), .cpu_hit_o(cpu_hit),
    .bus_req_o(bus_req), .bus_op_o(bus_op), .bus_idx_o(bus_idx),
    .bus_done_i(bus_done), .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_op_i(snp_op), .snp_idx_i(snp_idx),
    .snp_supply_o(snp_supply), .snp_flush_o(snp_flush), .snp_shared_o(snp_shared)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // compare all outputs against the model for the current inputs
  task automatic compare();
    int e_rdy = 0, e_hit = 0, e_sup = 0, e_fl = 0, e_sh = 0, st;
    string ctag = "R1", stag = "R11";
    if (m_pend) begin
      ctag = bus_done ? ((m_op == 1) ? "R4" : (m_op == 3) ? "R6" : "R7") : "R10";
      e_rdy = bus_done;
      e_hit = bus_done && m_op == 3;
    end else if (cpu_req) begin
      st = m_st[cpu_idx];
      if (!cpu_we) begin
        ctag = (st != I) ? "R2" : "R3";
        e_rdy = (st != I); e_hit = e_rdy;
      end else begin
        ctag = (st == S) ? "R6" : (st == I) ? "R7" : "R5";
        e_rdy = (st == M || st == E); e_hit = e_rdy;
      end
    end
    chk(ctag, "cpu_rdy", cpu_rdy, e_rdy);
    chk(ctag, "cpu_hit", cpu_hit, e_hit);
    chk("R10", "bus_req", bus_req, m_pend);
    chk("R10", "bus_op", bus_op, m_pend ? m_op : 0);
    if (m_pend) chk("R3", "bus_idx", bus_idx, m_idx);
    if (snp_valid) begin
      st = m_st[snp_idx];
      stag = (st == I || snp_op == 0) ? "R11" : (snp_op == 1) ? "R8" : "R9";
      e_sup = (snp_op == 1 && (st == E || st == M)) || (snp_op == 2 && st == M);
      e_fl  = (snp_op == 1 || snp_op == 2) && st == M;
      e_sh  = snp_op == 1 && st != I;
    end
    chk(stag, "snp_supply", snp_supply, e_sup);
    chk(stag, "snp_flush", snp_flush, e_fl);
    chk(stag, "snp_shared", snp_shared, e_sh);
  endtask

  task automatic model_update();
    int st;
    if (m_pend) begin
      if (bus_done) begin
        m_st[m_idx] = (m_op == 1) ? (bus_shared ? S : E) : M;
        m_pend = 0;
      end
    end else if (cpu_req) begin
      st = m_st[cpu_idx];
      if (cpu_we && st == E) m_st[cpu_idx] = M;
      else if ((cpu_we && (st == S || st == I)) || (!cpu_we && st == I)) begin
        m_pend = 1; m_idx = cpu_idx;
        m_op = !cpu_we ? 1 : (st == S) ? 3 : 2;
      end
    end
    if (snp_valid) begin
      st = m_st[snp_idx];
      if (snp_op == 1 && (st == E || st == M)) m_st[snp_idx] = S;
      else if (snp_op >= 2) m_st[snp_idx] = I;
    end
  endtask

  // called at negedge with inputs already set
  task automatic step();
    #1;
    compare();
    last_rdy = cpu_rdy;
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic access(bit we, int idx, int lat, bit shared, bit rnd_snoop);
    int cnt = 0;
    forever begin
      cpu_req = 1; cpu_we = we; cpu_idx = IW'(idx);
      bus_done = m_pend && cnt >= lat;
      bus_shared = shared;
      snp_valid = 0;
      if (rnd_snoop && ($urandom % 3 == 0)) begin
        snp_valid = 1;
        snp_op = 2'($urandom % 4);
        snp_idx = IW'((idx + 1 + ($urandom % (NL - 1))) % NL);
      end
      step();
      if (last_rdy) break;
      if (m_pend) cnt++;
    end
    cpu_req = 0; bus_done = 0; bus_shared = 0; snp_valid = 0;
  endtask

  task automatic snoop(int op, int idx);
    snp_valid = 1; snp_op = 2'(op); snp_idx = IW'(idx);
    step();
    snp_valid = 0;
  endtask

  initial begin
    for (int k = 0; k < NL; k++) m_st[k] = I;
    @(negedge clk);
    #1;
    chk("R1", "rdy in reset", cpu_rdy, 0);
    chk("R1", "bus_req in reset", bus_req, 0);
    @(negedge clk);
    rst_n = 1;
    step();                          // R1 idle compare
    access(0, 0, 2, 0, 0);           // R3 miss, R4 fill alone -> E
    access(0, 0, 0, 0, 0);           // R2 read hit E
    access(1, 0, 0, 0, 0);           // R5 silent E->M
    access(1, 0, 0, 0, 0);           // R5 write hit M
    access(0, 1, 1, 1, 0);           // R4 fill shared -> S
    access(0, 1, 0, 0, 0);           // R2 read hit S
    access(1, 1, 3, 0, 0);           // R6 upgrade
    access(1, 2, 0, 0, 0);           // R7 rfo
    snoop(1, 0);                     // R8 read on M: supply+flush
    access(0, 0, 0, 0, 0);           // R2 hit S
    access(1, 0, 1, 0, 0);           // R6 again
    access(0, 3, 0, 0, 0);           // R4 E
    snoop(1, 3);                     // R8 supply from E
    snoop(1, 3);                     // R8 shared only
    snoop(3, 3);                     // R9 invalidate
    access(0, 3, 0, 0, 0);           // R3 miss again
    snoop(2, 2);                     // R9 rfo on M
    snoop(2, 2);                     // R11 line now I
    snoop(0, 1);                     // R11 op none
    // R10: snoop other lines while a read is pending
    access(0, 5, 6, 0, 1);
    for (int n = 0; n < 400; n++)
      access(bit'($urandom % 2), $urandom % NL, $urandom % 4, bit'($urandom % 2), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule